// File: doc/BRIEF.md
# Escaped Frame Receiver with Sequence Filtering

This block sits after a byte-wide serial receiver. It rebuilds frames from the incoming byte stream. A frame starts at an opening 0xFF and ends at the next 0xFF, and bytes between frames are dropped. Inside a frame the block undoes a two-byte escape code and tracks a 16-bit CRC over the decoded bytes. The CRC check lags the input by two bytes, so the trailing checksum is never folded into itself. The block also keeps the first decoded byte, which serves as the sequence number of a data frame.

The decision is made when the closing delimiter is accepted. A frame is accepted only if it is intact, long enough, and not too long. A data frame must also carry the expected sequence number.

For every accepted frame, a one-cycle report gives:
- the acknowledgement number it carried;
- a running count of input bytes.

A retransmission controller can use the report to tell when enough traffic has gone by since its own frame was sent. The payload bytes of an accepted data frame are held in a small store and then released on a valid/ready output. Rejected frames leave no trace at the ports.

Back-pressure rules:
- `out_valid` stays high with `out_data` unchanged until `out_ready` is sampled high.
- While the payload is being released, `in_ready` is low, so the upstream byte source must hold its byte.
- At all other times `in_ready` is high and a byte moves on every cycle where `in_valid` is high.

Top module: `pkt_deframer`

## Requirements
- R1: Outside a frame, a byte other than 0xFF is ignored. A 0xFF outside a frame opens a frame, and the next unescaped 0xFF closes it. The closing 0xFF does not open another frame.
- R2: Inside a frame, the pair 0xCB 0x34 decodes to 0xFF and the pair 0xCB 0x00 decodes to 0xCB. A frame is discarded if 0xCB is followed by any other byte, or if 0xCB is followed directly by the closing 0xFF.
- R3: Of the decoded bytes, the last two are a checksum, high byte first. The checksum is CRC-16 with polynomial 0x1021 and start value 0xFFFF, processed most significant bit first, over all the decoded bytes before it. On a mismatch the frame is discarded.
- R4: A frame of fewer than three decoded bytes is discarded. A frame of exactly three decoded bytes is acknowledgement-only: it produces a report, no payload, and leaves the expected sequence number unchanged.
- R5: In a frame of four or more decoded bytes, the first byte is the sequence number. The frame is discarded unless that byte equals the expected value, which is 0 after reset. Each accepted data frame increments the expected value modulo 256.
- R6: For an accepted frame of L decoded bytes, the decoded bytes at positions 1 to L-4 leave on `out_data` in order. None leave before the frame is accepted, and none leave from a discarded frame.
- R7: `ack_valid` pulses for one cycle, in the cycle after the closing byte is accepted, for each accepted frame. With it, `ack_num` is the third-to-last decoded byte and `ack_bytes` is the number of input bytes accepted since reset, counting the closing delimiter, modulo 2^CNT_W.
- R8: A frame of more than DEPTH+4 decoded bytes is discarded. A frame of exactly DEPTH+4 decoded bytes is handled normally.
- R9: Once `out_valid` is high, it and `out_data` hold steady until `out_ready` is high. `in_ready` is low exactly while payload is being released.
- R10: After reset, `in_ready` is high, and `out_valid` and `ack_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Raw received byte |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Downstream takes the payload byte |
| out_data | output | 8 | Payload byte |
| ack_valid | output | 1 | One-cycle report of an accepted frame |
| ack_num | output | 8 | Acknowledgement number of that frame |
| ack_bytes | output | CNT_W | Input byte count at the frame's close |

## Verification
Each kind of internal fault shows at the ports in a different way, and within a bounded time:
- **Wrong expected sequence number.** The next data frame loses its report in the cycle after its closing byte, so the fault shows within one frame.
- **CRC lag or escape state out of step.** Every later frame is dropped, or a frame that should be dropped is reported, again at the next closing byte.
- **Slipped store address or release count.** A wrong byte, or a missing or extra byte, appears on the first transfer of that payload.

The reference model predicts the exact cycle of each report, so a late or early decision is caught as well as a wrong one.

// File: rtl/pktd_pkg.sv
package pktd_pkg;
  localparam logic [7:0]  DELIM      = 8'hFF;
  localparam logic [7:0]  ESC        = 8'hCB;
  localparam logic [7:0]  ESC_DELIM  = 8'h34;
  localparam logic [7:0]  ESC_SELF   = 8'h00;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;

  // One byte of CRC-16, most significant bit first.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/pktd_unescape.sv
module pktd_unescape
  import pktd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [7:0] raw,
  output logic       open_evt,
  output logic       close_evt,
  output logic       close_bad,
  output logic       dec_valid,
  output logic [7:0] dec_byte,
  output logic       esc_err
);
  logic in_frame_q, esc_q;
  logic is_delim, is_esc, esc_code_ok;

  assign is_delim    = (raw == DELIM);
  assign is_esc      = (raw == ESC);
  assign esc_code_ok = (raw == ESC_DELIM) || (raw == ESC_SELF);

  assign open_evt  = fire && !in_frame_q && is_delim;
  assign close_evt = fire && in_frame_q && is_delim;
  assign close_bad = close_evt && esc_q;
  assign dec_valid = fire && in_frame_q && !is_delim && (esc_q ? esc_code_ok : !is_esc);
  assign dec_byte  = esc_q ? ((raw == ESC_DELIM) ? DELIM : ESC) : raw;
  assign esc_err   = fire && in_frame_q && esc_q && !is_delim && !esc_code_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      esc_q      <= 1'b0;
    end else if (open_evt || close_evt) begin
      in_frame_q <= open_evt;
      esc_q      <= 1'b0;
    end else if (fire && in_frame_q) begin
      esc_q <= !esc_q && is_esc;
    end
  end
endmodule

// File: rtl/pktd_crc_track.sv
module pktd_crc_track
  import pktd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       dec_valid,
  input  logic [7:0] dec_byte,
  output logic       crc_match,
  output logic [7:0] ack_byte
);
  logic [15:0] crc_q;
  logic [7:0]  hold_old_q, hold_new_q, ack_q;
  logic [1:0]  depth_q;

  assign crc_match = (depth_q == 2'd2) && (crc_q == {hold_old_q, hold_new_q});
  assign ack_byte  = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      crc_q      <= CRC_SEED;
      hold_old_q <= '0;
      hold_new_q <= '0;
      ack_q      <= '0;
      depth_q    <= '0;
    end else if (dec_valid) begin
      // A byte enters the CRC only once two newer bytes follow it.
      if (depth_q == 2'd2) begin
        crc_q <= crc_step(crc_q, hold_old_q);
        ack_q <= hold_old_q;
      end else begin
        depth_q <= depth_q + 2'd1;
      end
      hold_old_q <= hold_new_q;
      hold_new_q <= dec_byte;
    end
  end
endmodule

// File: rtl/pktd_payload_buf.sv
module pktd_payload_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             ack_valid,
  output logic [7:0]       ack_num,
  output logic [CNT_W-1:0] ack_bytes
);
  localparam int MAX_LEN = DEPTH + 4;
  localparam int LW      = $clog2(MAX_LEN + 1);
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic       fire;
  logic       open_evt, close_evt, close_bad, dec_valid, esc_err;
  logic [7:0] dec_byte;
  logic       crc_match;
  logic [7:0] ack_byte;

  logic [LW-1:0]    len_q;
  logic             bad_q;
  logic [7:0]       seq_byte_q, exp_seq_q;
  logic             rel_q;
  logic [AW-1:0]    rd_q, rd_last_q;
  logic             ack_valid_q;
  logic [7:0]       ack_num_q;
  logic [CNT_W-1:0] ack_bytes_q, rx_cnt_q;

  logic             is_data, has_payload, frame_good, buf_we;
  logic [AW-1:0]    waddr;
  logic [7:0]       rdata;

  assign in_ready = !rel_q;
  assign fire     = in_valid && in_ready;

  pktd_unescape u_unesc (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .raw      (in_data),
    .open_evt (open_evt),
    .close_evt(close_evt),
    .close_bad(close_bad),
    .dec_valid(dec_valid),
    .dec_byte (dec_byte),
    .esc_err  (esc_err)
  );

  pktd_crc_track u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (open_evt),
    .dec_valid(dec_valid),
    .dec_byte (dec_byte),
    .crc_match(crc_match),
    .ack_byte (ack_byte)
  );

  // Decoded byte k (k >= 1) goes to slot k-1; byte 0 is the sequence number.
  assign buf_we = dec_valid && (len_q != '0) && (len_q <= LW'(DEPTH));
  assign waddr  = AW'(len_q - LW'(1));

  pktd_payload_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(waddr),
    .wdata(dec_byte),
    .raddr(rd_q),
    .rdata(rdata)
  );

  assign is_data     = len_q >= LW'(4);
  assign has_payload = len_q > LW'(4);
  assign frame_good  = close_evt && !close_bad && !bad_q && (len_q >= LW'(3)) &&
                       crc_match && (!is_data || (seq_byte_q == exp_seq_q));

  assign out_valid = rel_q;
  assign out_data  = rdata;
  assign ack_valid = ack_valid_q;
  assign ack_num   = ack_num_q;
  assign ack_bytes = ack_bytes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q       <= '0;
      bad_q       <= 1'b0;
      seq_byte_q  <= '0;
      exp_seq_q   <= '0;
      rel_q       <= 1'b0;
      rd_q        <= '0;
      rd_last_q   <= '0;
      ack_valid_q <= 1'b0;
      ack_num_q   <= '0;
      ack_bytes_q <= '0;
      rx_cnt_q    <= '0;
    end else begin
      ack_valid_q <= 1'b0;
      if (fire) rx_cnt_q <= rx_cnt_q + CNT_W'(1);
      if (open_evt) begin
        len_q <= '0;
        bad_q <= 1'b0;
      end
      if (dec_valid) begin
        if (len_q == LW'(MAX_LEN)) bad_q <= 1'b1;
        else                       len_q <= len_q + LW'(1);
        if (len_q == '0) seq_byte_q <= dec_byte;
      end
      if (esc_err) bad_q <= 1'b1;
      if (frame_good) begin
        ack_valid_q <= 1'b1;
        ack_num_q   <= ack_byte;
        ack_bytes_q <= rx_cnt_q + CNT_W'(1);
        if (is_data) exp_seq_q <= exp_seq_q + 8'd1;
        if (has_payload) begin
          rel_q     <= 1'b1;
          rd_q      <= '0;
          rd_last_q <= AW'(len_q - LW'(5));
        end
      end
      if (rel_q && out_ready) begin
        if (rd_q == rd_last_q) rel_q <= 1'b0;
        else                   rd_q  <= rd_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/pkt_deframer_chk.sv
module pkt_deframer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       ack_valid
);
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_no_input_in_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);

  assert_ack_follows_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(in_valid && in_ready && (in_data == 8'hFF)));

  assert_release_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ack_valid);
endmodule

bind pkt_deframer pkt_deframer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .ack_valid(ack_valid)
);

// File: tb/sim_pkt_deframer.sv
`timescale 1ns/1ps
module sim_pkt_deframer;
  localparam int DEPTH = 16;
  localparam int MAXL  = DEPTH + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        ack_valid;
  logic [7:0]  ack_num;
  logic [15:0] ack_bytes;

  pkt_deframer #(.DEPTH(DEPTH), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ack_valid(ack_valid), .ack_num(ack_num), .ack_bytes(ack_bytes)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit slow = 1'b0;
  string cur_req = "R10";

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  bit         m_in = 0, m_esc = 0, m_bad = 0;
  logic [7:0] m_q[$];
  logic [7:0] m_seq = 8'd0;
  int         m_count = 0;
  int         ex_cyc[$];
  int         ex_ack[$];
  int         ex_cnt[$];
  logic [7:0] ex_data[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      bit fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic model_byte(input logic [7:0] b, input int hs_cyc);
    m_count++;
    if (!m_in) begin
      if (b == 8'hFF) begin m_in = 1; m_esc = 0; m_bad = 0; m_q.delete(); end
    end else if (b == 8'hFF) begin
      int L = m_q.size();
      bit good = !m_bad && !m_esc && L >= 3 && L <= MAXL;
      m_in = 0;
      if (good) begin
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < L - 2; i++) c = crc_ref(c, m_q[i]);
        if (c != {m_q[L-2], m_q[L-1]}) good = 0;
      end
      if (good && L >= 4 && m_q[0] != m_seq) good = 0;
      if (good) begin
        ex_cyc.push_back(hs_cyc);
        ex_ack.push_back(int'(m_q[L-3]));
        ex_cnt.push_back(m_count & 16'hFFFF);
        if (L >= 4) begin
          m_seq = m_seq + 8'd1;
          for (int i = 1; i <= L - 4; i++) ex_data.push_back(m_q[i]);
        end
      end
    end else if (m_esc) begin
      m_esc = 0;
      if (b == 8'h34) m_q.push_back(8'hFF);
      else if (b == 8'h00) m_q.push_back(8'hCB);
      else m_bad = 1;
    end else if (b == 8'hCB) m_esc = 1;
    else m_q.push_back(b);
  endtask

  // Called at a falling edge; returns at the falling edge after the handshake.
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    model_byte(b, cyc + 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_enc(input logic [7:0] b);
    if (b == 8'hFF) begin send_byte(8'hCB); send_byte(8'h34); end
    else if (b == 8'hCB) begin send_byte(8'hCB); send_byte(8'h00); end
    else send_byte(b);
  endtask

  task automatic send_dec(input logic [7:0] body[$], input bit bad_crc);
    logic [15:0] c = 16'hFFFF;
    foreach (body[i]) c = crc_ref(c, body[i]);
    if (bad_crc) c = c ^ 16'h0001;
    send_byte(8'hFF);
    foreach (body[i]) send_enc(body[i]);
    send_enc(c[15:8]);
    send_enc(c[7:0]);
    send_byte(8'hFF);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    chk(ex_cyc.size() == 0, cur_req, "reports still expected", ex_cyc.size(), 0);
    chk(ex_data.size() == 0, cur_req, "payload bytes still expected", ex_data.size(), 0);
  endtask

  // Compared every cycle, away from the active edge.
  always @(negedge clk) begin
    out_ready = slow ? ((cyc % 3) != 1) : 1'b1;
    if (rst_n) begin
      if (ack_valid) begin
        if (ex_cyc.size() == 0) begin
          chk(0, cur_req, "R7 unexpected report ack_num", ack_num, 0);
        end else begin
          chk(ex_cyc[0] == cyc, cur_req, "R7 report cycle", cyc, ex_cyc[0]);
          chk(ack_num == ex_ack[0][7:0], cur_req, "R7 ack_num", ack_num, ex_ack[0]);
          chk(ack_bytes == ex_cnt[0][15:0], cur_req, "R7 ack_bytes", ack_bytes, ex_cnt[0]);
          void'(ex_cyc.pop_front()); void'(ex_ack.pop_front()); void'(ex_cnt.pop_front());
        end
      end else if (ex_cyc.size() > 0 && ex_cyc[0] <= cyc) begin
        chk(0, cur_req, "R7 missing report at cycle", cyc, ex_cyc[0]);
        void'(ex_cyc.pop_front()); void'(ex_ack.pop_front()); void'(ex_cnt.pop_front());
      end
      if (out_valid && out_ready) begin
        if (ex_data.size() == 0) chk(0, cur_req, "R6 unexpected payload byte", out_data, 0);
        else begin
          chk(out_data == ex_data[0], cur_req, "R6 payload byte", out_data, ex_data[0]);
          void'(ex_data.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] body[$];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10";
    chk(in_ready == 1'b1, cur_req, "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, cur_req, "out_valid after reset", out_valid, 0);
    chk(ack_valid == 1'b0, cur_req, "ack_valid after reset", ack_valid, 0);

    cur_req = "R4"; // three decoded bytes: report only
    body = '{8'h55}; send_dec(body, 0); settle(10);

    cur_req = "R2"; // escaped 0xFF and 0xCB in payload, R6 order
    body = '{8'h00, 8'h11, 8'hFF, 8'hCB, 8'h22, 8'h9A}; send_dec(body, 0); settle(20);

    cur_req = "R5"; // repeated sequence number is dropped
    body = '{8'h00, 8'h33, 8'h01}; send_dec(body, 0); settle(10);

    cur_req = "R3"; // corrupted checksum is dropped
    body = '{8'h01, 8'h44, 8'h02}; send_dec(body, 1); settle(10);

    cur_req = "R5"; // data frame with empty payload
    body = '{8'h01, 8'h03}; send_dec(body, 0); settle(10);

    cur_req = "R1"; // bytes between frames are ignored
    send_byte(8'h12); send_byte(8'hCB); send_byte(8'h34); send_byte(8'h00);
    body = '{8'h02, 8'h55, 8'h66, 8'h04}; send_dec(body, 0); settle(15);

    cur_req = "R2"; // bad escape code
    send_byte(8'hFF); send_byte(8'h03); send_byte(8'hCB); send_byte(8'h12);
    send_byte(8'h05); send_byte(8'h00); send_byte(8'h00); send_byte(8'hFF); settle(10);

    cur_req = "R2"; // escape byte right before closing delimiter
    send_byte(8'hFF); send_byte(8'h03); send_byte(8'h05); send_byte(8'hCB); send_byte(8'hFF);
    settle(10);

    cur_req = "R4"; // too short
    send_byte(8'hFF); send_byte(8'hFF);
    body = '{}; send_dec(body, 0); settle(10);

    cur_req = "R8"; // one decoded byte over the limit
    body = '{m_seq};
    for (int i = 0; i < DEPTH + 1; i++) body.push_back(8'(8'h40 + i));
    body.push_back(8'h77); send_dec(body, 0); settle(10);

    cur_req = "R8"; // exactly at the limit, with slow downstream (R9)
    slow = 1'b1;
    body = '{m_seq};
    for (int i = 0; i < DEPTH; i++) body.push_back(8'(8'hA0 + i));
    body.push_back(8'h78); send_dec(body, 0); settle(60);

    cur_req = "R9"; // back-to-back frames under back-pressure
    for (int k = 0; k < 4; k++) begin
      body = '{m_seq, 8'(k), 8'hCB, 8'(k + 8'h10), 8'(k + 8'h20)}; send_dec(body, 0);
    end
    settle(40);
    slow = 1'b0;

    cur_req = "R5"; // sequence number wraps past 255
    for (int k = 0; k < 260; k++) begin
      body = '{m_seq, 8'(k), 8'(k + 1)}; send_dec(body, 0);
    end
    settle(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule